// File: doc/BRIEF.md
# Single-Wire Debug Sync Responder

This block sits on the target side of a one-wire, open-drain debug link. It watches the sensed level of the wire and counts bit-clock enables while the wire is held low. A low that lasts a programmable number of bit-cycles is taken as a synchronization request from the host. The responder then throws away whatever the command receiver had half-collected by issuing a one-clock soft reset, and cancels any acknowledge pulse still waiting to go out. It then answers with a timed reference pulse from which the host can measure the link speed.

The reply has a fixed shape. The responder first waits for the host to let the wire go high. It then stays quiet for 16 bit-cycles, pulls the wire low for 128 bit-cycles and drives it high for one bit-cycle to sharpen the rising edge, after which it releases the wire. While the responder is idle, every falling edge on the wire is reported to the command receiver as the possible start of a new frame. The `line_in` input is assumed to be already synchronized to `clk`, and `bit_tick` is a one-clock enable at the current link speed.

Top module: `sync_responder`

## Requirements
- R1: During and right after reset, `drive_low`, `drive_high`, `soft_reset`, `ack_cancel`, `busy` and `cmd_start` are all 0.
- R2: When idle, a low on `line_in` that spans `det_limit` bit ticks produces exactly one `soft_reset` pulse, one clock wide, in the clock after the tick that completes the count.
- R3: `busy` rises together with `soft_reset` and stays high until the clock after the last speedup tick. It then falls, with `drive_high` having been high in the clock before.
- R4: After a request is detected, neither drive output is active as long as the host keeps the line low.
- R5: Once the line is seen high, the responder waits 16 bit ticks with no drive. With a tick every clock, `drive_low` first shows 17 clocks after the host releases the line.
- R6: `drive_low` stays high for exactly 128 bit ticks (128 clocks with a tick every clock).
- R7: The clock after `drive_low` falls, `drive_high` is high for exactly one bit tick. The two drives are never high together.
- R8: `ack_cancel` pulses in the same clock as `soft_reset` only if `ack_pending` was 1 in the detecting clock; otherwise it stays 0.
- R9: While idle, a high-to-low change on `line_in` gives a one-clock `cmd_start` pulse in the next clock. Edges during a reply give none.
- R10: A low that ends after `det_limit`-1 ticks causes no `soft_reset`. The threshold follows the `det_limit` input, which must be at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | 1 | Synchronized level of the debug wire |
| bit_tick | input | 1 | One-clock enable per link bit-cycle |
| det_limit | input | DET_W | Low length in ticks that counts as a request |
| ack_pending | input | 1 | An acknowledge pulse is waiting to be sent |
| drive_low | output | 1 | Pull the wire low |
| drive_high | output | 1 | Drive the wire high (speedup) |
| soft_reset | output | 1 | One-clock discard pulse to the command receiver |
| ack_cancel | output | 1 | One-clock abort pulse to the acknowledge generator |
| busy | output | 1 | Request being served |
| cmd_start | output | 1 | Falling edge seen while idle |

## Verification
Every pulse output (`soft_reset`, `ack_cancel`, `cmd_start`) is due one clock after the edge whose inputs qualify it. Drive outputs change one clock after the tick that closes a phase. The bench updates a behavioural model on the rising edge from the same inputs the design sees, and compares all six outputs on the following falling edge, so every output is checked in the clock it is due. With a tick every clock, directed checks also count the clocks from host release to the low pulse (17), the length of the low pulse (128) and the length of the speedup (1), and confirm a short low produces no reset.

// File: rtl/sync_resp_pkg.sv
package sync_resp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_GAP,
    ST_PULSE,
    ST_SPEED
  } rsp_state_e;

  // True when one more step brings a zero-based counter to the target length.
  function automatic logic reaches_count(input logic [15:0] count, input logic [15:0] target);
    return (count + 16'd1) == target;
  endfunction

endpackage

// File: rtl/low_timer.sv
module low_timer #(
  parameter int DET_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             line_in,
  input  logic             bit_tick,
  input  logic [DET_W-1:0] det_limit,
  output logic             detect
);
  import sync_resp_pkg::*;

  logic [DET_W-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (!armed || line_in) begin
      low_cnt <= '0;
    end else if (bit_tick) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign detect = armed && !line_in && bit_tick &&
                  reaches_count(16'(low_cnt), 16'(det_limit));

endmodule

// File: rtl/reply_seq.sv
module reply_seq #(
  parameter int GAP_TICKS   = 16,
  parameter int PULSE_TICKS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic detect,
  input  logic line_in,
  input  logic bit_tick,
  input  logic ack_pending,
  output logic armed,
  output logic drive_low,
  output logic drive_high,
  output logic soft_reset,
  output logic ack_cancel,
  output logic busy
);
  import sync_resp_pkg::*;

  localparam int MAX_TICKS = (PULSE_TICKS > GAP_TICKS) ? PULSE_TICKS : GAP_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS) + 1;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  rsp_state_e       state;
  logic [CNT_W-1:0] phase_cnt;

  // Named events for the assertions and for reading waveforms.
  logic in_hold;
  logic gap_done;
  logic pulse_done;
  logic speed_done;

  assign in_hold    = (state == ST_HOLD);
  assign gap_done   = (state == ST_GAP) && bit_tick &&
                      reaches_count(16'(phase_cnt), 16'(GAP_TICKS));
  assign pulse_done = (state == ST_PULSE) && bit_tick &&
                      reaches_count(16'(phase_cnt), 16'(PULSE_TICKS));
  assign speed_done = (state == ST_SPEED) && bit_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      phase_cnt  <= '0;
      soft_reset <= 1'b0;
      ack_cancel <= 1'b0;
    end else begin
      soft_reset <= detect;
      ack_cancel <= detect && ack_pending;
      unique case (state)
        ST_IDLE: begin
          if (detect) state <= ST_HOLD;
        end
        ST_HOLD: begin
          if (line_in) begin
            state     <= ST_GAP;
            phase_cnt <= '0;
          end
        end
        ST_GAP: begin
          if (gap_done) begin
            state     <= ST_PULSE;
            phase_cnt <= '0;
          end else if (bit_tick) begin
            phase_cnt <= phase_cnt + CNT_ONE;
          end
        end
        ST_PULSE: begin
          if (pulse_done) begin
            state     <= ST_SPEED;
            phase_cnt <= '0;
          end else if (bit_tick) begin
            phase_cnt <= phase_cnt + CNT_ONE;
          end
        end
        ST_SPEED: begin
          if (speed_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign armed      = (state == ST_IDLE);
  assign drive_low  = (state == ST_PULSE);
  assign drive_high = (state == ST_SPEED);
  assign busy       = !armed;

  // R2: the discard pulse is one clock wide
  assert_soft_reset_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> !soft_reset);

  // R3: busy is already up when the discard pulse shows
  assert_busy_with_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |-> busy);

  // R3: busy only drops right after the speedup
  assert_busy_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(drive_high));

  // R4: a held line keeps the responder in the hold phase without driving
  assert_hold_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && !line_in) |=> (in_hold && !drive_low && !drive_high));

  // R7: the low pulse is followed directly by the speedup
  assert_speedup_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_low) |-> drive_high);

  // R8: an abort only goes out alongside a discard pulse
  assert_cancel_with_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_cancel |-> soft_reset);

endmodule

// File: rtl/edge_watch.sv
module edge_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic line_in,
  output logic cmd_start
);

  logic line_prev;
  logic fall_seen;

  assign fall_seen = armed && line_prev && !line_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_prev <= 1'b1;
      cmd_start <= 1'b0;
    end else begin
      line_prev <= line_in;
      cmd_start <= fall_seen;
    end
  end

  // R9: a frame start is reported once per falling edge
  assert_start_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);

endmodule

// File: rtl/sync_responder.sv
module sync_responder #(
  parameter int DET_W       = 8,
  parameter int GAP_TICKS   = 16,
  parameter int PULSE_TICKS = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  input  logic             bit_tick,
  input  logic [DET_W-1:0] det_limit,
  input  logic             ack_pending,
  output logic             drive_low,
  output logic             drive_high,
  output logic             soft_reset,
  output logic             ack_cancel,
  output logic             busy,
  output logic             cmd_start
);

  logic armed;
  logic detect;

  low_timer #(.DET_W(DET_W)) u_low_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed     (armed),
    .line_in   (line_in),
    .bit_tick  (bit_tick),
    .det_limit (det_limit),
    .detect    (detect)
  );

  reply_seq #(.GAP_TICKS(GAP_TICKS), .PULSE_TICKS(PULSE_TICKS)) u_reply_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .detect      (detect),
    .line_in     (line_in),
    .bit_tick    (bit_tick),
    .ack_pending (ack_pending),
    .armed       (armed),
    .drive_low   (drive_low),
    .drive_high  (drive_high),
    .soft_reset  (soft_reset),
    .ack_cancel  (ack_cancel),
    .busy        (busy)
  );

  edge_watch u_edge_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed     (armed),
    .line_in   (line_in),
    .cmd_start (cmd_start)
  );

  // R7: the two drivers never fight
  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_low && drive_high));

endmodule

// File: tb/tb_sync_responder.sv
`timescale 1ns/1ps
module tb_sync_responder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_low = 1'b0;
  logic       tick = 1'b1;
  logic [7:0] lim = 8'd20;
  logic       ack = 1'b0;
  logic       drive_low, drive_high, soft_reset, ack_cancel, busy, cmd_start;
  wire        line = !(host_low || drive_low);

  always #2.5 clk = ~clk;

  sync_responder dut (
    .clk(clk), .rst_n(rst_n), .line_in(line), .bit_tick(tick),
    .det_limit(lim), .ack_pending(ack),
    .drive_low(drive_low), .drive_high(drive_high), .soft_reset(soft_reset),
    .ack_cancel(ack_cancel), .busy(busy), .cmd_start(cmd_start)
  );

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int div = 1;
  int divc = 0;
  int sr_seen = 0, ac_seen = 0, cs_seen = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Tick generator, changed only on falling edges.
  always @(negedge clk) begin
    if (divc >= div - 1) begin divc = 0; tick = 1'b1; end
    else begin divc = divc + 1; tick = 1'b0; end
  end

  // Behavioural model: phase number plus counters, updated at the rising edge.
  int  m_phase = 0;
  int  m_low = 0;
  int  m_ticks = 0;
  bit  m_prev = 1'b1;
  bit  e_sr = 0, e_ac = 0, e_cs = 0;
  bit  m_line, m_det;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_low = 0; m_ticks = 0; m_prev = 1'b1;
      e_sr = 0; e_ac = 0; e_cs = 0;
    end else begin
      m_line = !(host_low || (m_phase == 3));
      m_det  = (m_phase == 0) && !m_line && tick && (m_low + 1 == int'(lim));
      e_cs   = (m_phase == 0) && m_prev && !m_line;
      e_sr   = m_det;
      e_ac   = m_det && ack;
      m_prev = m_line;
      if (m_phase != 0 || m_line) m_low = 0;
      else if (tick) m_low = m_low + 1;
      case (m_phase)
        0: if (m_det) m_phase = 1;
        1: if (m_line) begin m_phase = 2; m_ticks = 0; end
        2: if (tick) begin m_ticks++; if (m_ticks == 16) begin m_phase = 3; m_ticks = 0; end end
        3: if (tick) begin m_ticks++; if (m_ticks == 128) begin m_phase = 4; m_ticks = 0; end end
        4: if (tick) m_phase = 0;
        default: m_phase = 0;
      endcase
    end
  end

  // Per-clock comparison against the model, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(soft_reset == e_sr, "R2 soft_reset", soft_reset, e_sr);
      chk(busy == (m_phase != 0), "R3 busy", busy, m_phase != 0);
      chk(drive_low == (m_phase == 3), "R6 drive_low", drive_low, m_phase == 3);
      chk(drive_high == (m_phase == 4), "R7 drive_high", drive_high, m_phase == 4);
      chk(ack_cancel == e_ac, "R8 ack_cancel", ack_cancel, e_ac);
      chk(cmd_start == e_cs, "R9 cmd_start", cmd_start, e_cs);
      if (soft_reset) sr_seen++;
      if (ack_cancel) ac_seen++;
      if (cmd_start) cs_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      fails++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic hold_low(input int n);
    host_low = 1'b1;
    repeat (n) @(negedge clk);
    host_low = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int k, n, m, base;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({drive_low, drive_high, soft_reset, ack_cancel, busy, cmd_start} == 6'b0,
        "R1 reset outputs", {drive_low, drive_high, soft_reset, ack_cancel, busy, cmd_start}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({drive_low, drive_high, soft_reset, busy} == 4'b0, "R1 after reset",
        {drive_low, drive_high, soft_reset, busy}, 0);
    repeat (4) @(negedge clk);

    // R10: one tick short of the limit is not a request
    hold_low(19);
    repeat (6) @(negedge clk);
    chk(sr_seen == 0, "R10 short low ignored", sr_seen, 0);
    chk(busy == 0, "R10 still idle", busy, 0);

    // Full request with a tick every clock
    base = sr_seen;
    host_low = 1'b1;
    repeat (25) @(negedge clk);
    chk(busy == 1 && drive_low == 0 && drive_high == 0, "R4 quiet while held",
        {busy, drive_low, drive_high}, 3'b100);
    chk(sr_seen == base + 1, "R2 one reset pulse", sr_seen, base + 1);
    repeat (10) @(negedge clk);
    host_low = 1'b0;
    k = 0;
    do begin @(negedge clk); k++; end while (!drive_low && k < 200);
    chk(k == 17, "R5 gap before pulse", k, 17);
    n = 0;
    while (drive_low && n < 400) begin @(negedge clk); n++; end
    chk(n == 128, "R6 pulse length", n, 128);
    m = 0;
    while (drive_high && m < 10) begin @(negedge clk); m++; end
    chk(m == 1, "R7 speedup length", m, 1);
    chk(busy == 0, "R3 released", busy, 0);
    repeat (4) @(negedge clk);

    // R9: a short host low after the reply is a frame start
    base = cs_seen;
    hold_low(2);
    repeat (4) @(negedge clk);
    chk(cs_seen == base + 1, "R9 frame start after reply", cs_seen, base + 1);

    // R8: request while an acknowledge waits
    base = ac_seen;
    ack = 1'b1;
    hold_low(24);
    ack = 1'b0;
    wait_idle();
    chk(ac_seen == base + 1, "R8 abort pulse", ac_seen, base + 1);

    // R8: no abort when nothing is pending
    base = ac_seen;
    hold_low(24);
    wait_idle();
    chk(ac_seen == base, "R8 no abort", ac_seen, base);

    // R10: slower link, larger threshold
    div = 3; lim = 8'd40;
    base = sr_seen;
    hold_low(3 * 39 - 2);
    repeat (8) @(negedge clk);
    chk(sr_seen == base, "R10 short low at new limit", sr_seen, base);
    hold_low(150);
    wait_idle();
    chk(sr_seen == base + 1, "R10 request at new limit", sr_seen, base + 1);
    repeat (10) @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule